// File: doc/BRIEF.md
# Eight-Line Programmable Interrupt Controller

This block collects eight interrupt request lines and presents one interrupt output to a processor. Software talks to it through two byte-wide register locations selected by a one-bit address, using plain write and read strobes. Offset 0 takes commands and the first word of an initialization sequence. Offset 1 takes the remaining initialization words and, in normal operation, the interrupt mask. A request is latched when its input rises. The output is raised when a pending request that is not masked outranks everything currently in service; line 0 has the highest priority. The processor takes the winning request with a one-cycle acknowledge pulse and later releases it with an end-of-interrupt command.

The register bus has no back-pressure. Every write strobe is accepted in the cycle it is presented. A read strobe loads the read data register at the next clock edge with the value selected before that edge. The stored vector base is made available as an output only; no vector is driven onto the bus.

Top module: `pic_regif`

## Requirements
- R1: After reset, the request, in-service and mask registers are zero, no initialization is in progress, reads of offset 0 return the request register, the vector base is 0 and the interrupt output is low.
- R2: A write to offset 0 with bit 4 set starts initialization, also when a sequence is already under way. Its bits 3, 1 and 0 change nothing. The sequence always consumes exactly three further writes to offset 1.
- R3: The first offset-1 write after initialization starts loads the vector base output from data bits 7:3. The second offset-1 write is ignored. The third offset-1 write ends initialization. None of these three writes changes the mask.
- R4: A write to offset 0 with bit 4 clear ends any initialization in progress and is decoded as a command. After that, offset-1 writes load the mask.
- R5: Command 0x0A makes later reads of offset 0 return the request register. Command 0x0B makes them return the in-service register. A read strobe loads rdata at the next edge with the value the selected register held before that edge.
- R6: Command 0x20 clears every request bit whose in-service bit is set, then clears the whole in-service register.
- R7: Command 0x60 plus L, with L from 0 to 7, clears the request bit and the in-service bit of line L.
- R8: Outside initialization, a write to offset 1 loads the 8-bit mask, where bit i masks line i. Reads of offset 1 return the mask.
- R9: Commands 0x68 and 0xC0 to 0xC7, and any other offset-0 value with bit 4 clear that is not listed in R5 to R7, leave the request, in-service and mask registers and the read select unchanged.
- R10: A request bit is set on a low-to-high transition of its input. An input held high does not set the bit again after it has been cleared. A new transition wins over a clear of the same bit in the same cycle.
- R11: The interrupt output is high exactly when some request bit i is set and unmasked, and no in-service bit at index i or lower is set.
- R12: An acknowledge pulse while the interrupt output is high clears the request bit of the lowest-index eligible line and sets its in-service bit. An acknowledge while the output is low has no effect. If an acknowledge arrives in the same cycle as command 0x20, the in-service register holds only the acknowledged line afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 1 | Register offset (0 command, 1 data/mask) |
| wdata | input | 8 | Write data |
| wr | input | 1 | Write strobe, one cycle per write |
| rd | input | 1 | Read strobe, one cycle per read |
| rdata | output | 8 | Registered read data |
| irq_in | input | 8 | Interrupt request lines, bit i is line i |
| ack | input | 1 | Interrupt acknowledge pulse |
| int_out | output | 1 | Interrupt request to the processor |
| vec_base | output | 5 | Stored vector base (bits 7:3 of the second init word) |

## Verification
Two collisions matter most. An acknowledge can coincide with an end-of-interrupt command, and a fresh rising edge on a line can coincide with the clear of that same request bit. The bench forces both collisions directly: it acknowledges in the same cycle as command 0x20, and it raises a line in the cycle that the line is acknowledged or released. Random traffic then keeps provoking them with acknowledges, commands and request toggles drawn from a fixed seed. Each outcome is compared, through register reads and the interrupt output, with a bench model that applies the ordering rules of R6, R10 and R12.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int PIC_DATA_W = 8;
  localparam int PIC_LINES  = 8;

  typedef enum logic [1:0] {
    INIT_IDLE = 2'd0,
    INIT_W2   = 2'd1,
    INIT_W3   = 2'd2,
    INIT_W4   = 2'd3
  } init_st_t;

  typedef enum logic {
    SEL_REQ = 1'b0,
    SEL_SVC = 1'b1
  } rsel_t;

  localparam logic [7:0] CMD_SEL_REQ = 8'h0A;
  localparam logic [7:0] CMD_SEL_SVC = 8'h0B;
  localparam logic [7:0] CMD_NSEOI   = 8'h20;
  localparam logic [4:0] CMD_SEOI_HI = 5'b01100;
endpackage

// File: rtl/pic_cmd_decode.sv
module pic_cmd_decode #(
  parameter int DATA_W = 8,
  parameter int LINE_W = 3
) (
  input  logic              wr,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              icw1,
  output logic              ocw,
  output logic              data1,
  output logic              sel_req,
  output logic              sel_svc,
  output logic              nseoi,
  output logic              seoi,
  output logic [LINE_W-1:0] seoi_line
);
  import pic_pkg::*;

  always_comb begin
    icw1      = wr && !addr && wdata[4];
    ocw       = wr && !addr && !wdata[4];
    data1     = wr && addr;
    sel_req   = ocw && (wdata == CMD_SEL_REQ);
    sel_svc   = ocw && (wdata == CMD_SEL_SVC);
    nseoi     = ocw && (wdata == CMD_NSEOI);
    seoi      = ocw && (wdata[7:3] == CMD_SEOI_HI);
    seoi_line = wdata[LINE_W-1:0];
  end
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq #(
  parameter int VB_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            icw1,
  input  logic            ocw,
  input  logic            data1,
  input  logic [VB_W-1:0] vb_din,
  output logic            mask_we,
  output logic [VB_W-1:0] vec_base
);
  import pic_pkg::*;

  init_st_t st;

  assign mask_we = data1 && (st == INIT_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= INIT_IDLE;
      vec_base <= '0;
    end else if (icw1) begin
      st <= INIT_W2;
    end else if (ocw) begin
      st <= INIT_IDLE;
    end else if (data1) begin
      case (st)
        INIT_W2: begin
          vec_base <= vb_din;
          st       <= INIT_W3;
        end
        INIT_W3: st <= INIT_W4;
        INIT_W4: st <= INIT_IDLE;
        default: st <= INIT_IDLE;
      endcase
    end
  end

  p_w4_returns_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (data1 && !icw1 && (st == INIT_W4)) |=> (st == INIT_IDLE));

  p_vb_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (data1 && (st == INIT_W2)) |=> (vec_base == $past(vb_din)));

  p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    icw1 |=> (st == INIT_W2));

  p_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ocw |=> (st == INIT_IDLE));
endmodule

// File: rtl/pic_prio_core.sv
module pic_prio_core #(
  parameter int N_IRQ  = 8,
  parameter int LINE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IRQ-1:0]  irq_in,
  input  logic              ack,
  input  logic              nseoi,
  input  logic              seoi,
  input  logic [LINE_W-1:0] seoi_line,
  input  logic              mask_we,
  input  logic [N_IRQ-1:0]  mask_din,
  output logic [N_IRQ-1:0]  irr,
  output logic [N_IRQ-1:0]  isr,
  output logic [N_IRQ-1:0]  imr,
  output logic              int_out
);
  logic [N_IRQ-1:0] prev_in, rise, svc_upto, cand, grant, line_oh;
  logic [N_IRQ-1:0] clr_req, clr_svc;

  assign rise = irq_in & ~prev_in;

  generate
    for (genvar i = 0; i < N_IRQ; i++) begin : g_ceil
      if (i == 0) begin : g_first
        assign svc_upto[i] = isr[i];
      end else begin : g_rest
        assign svc_upto[i] = svc_upto[i-1] | isr[i];
      end
    end
  endgenerate

  assign cand    = irr & ~imr & ~svc_upto;
  assign int_out = |cand;
  assign grant   = ack ? (cand & (~cand + N_IRQ'(1))) : '0;
  assign line_oh = N_IRQ'(1) << seoi_line;

  always_comb begin
    clr_req = grant;
    clr_svc = '0;
    if (nseoi) begin
      clr_req = clr_req | isr;
      clr_svc = '1;
    end
    if (seoi) begin
      clr_req = clr_req | line_oh;
      clr_svc = clr_svc | line_oh;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_in <= '0;
      irr     <= '0;
      isr     <= '0;
      imr     <= '0;
    end else begin
      prev_in <= irq_in;
      irr     <= (irr & ~clr_req) | rise;
      isr     <= (isr & ~clr_svc) | grant;
      if (mask_we) imr <= mask_din;
    end
  end

  p_nseoi_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (nseoi && !ack) |=> (isr == '0));

  p_seoi_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (seoi && !ack) |=> !isr[$past(seoi_line)]);

  p_ack_adds_one_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && int_out && !nseoi && !seoi) |=> ($countones(isr) == $countones($past(isr)) + 1));

  p_ack_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !int_out && !nseoi && !seoi) |=> $stable(isr));

  p_all_masked_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (imr == '1) |-> !int_out);

  p_rise_latches_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_in[0] && !prev_in[0]) |=> irr[0]);
endmodule

// File: rtl/pic_regif.sv
module pic_regif #(
  parameter int DATA_W = 8,
  parameter int N_IRQ  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr,
  input  logic              rd,
  output logic [DATA_W-1:0] rdata,
  input  logic [N_IRQ-1:0]  irq_in,
  input  logic              ack,
  output logic              int_out,
  output logic [DATA_W-4:0] vec_base
);
  import pic_pkg::*;

  localparam int LINE_W = $clog2(N_IRQ);
  localparam int VB_W   = DATA_W - 3;

  logic icw1, ocw, data1, sel_req, sel_svc, nseoi, seoi, mask_we;
  logic [LINE_W-1:0] seoi_line;
  logic [N_IRQ-1:0]  irr, isr, imr;
  rsel_t             rsel;
  logic [DATA_W-1:0] rd_mux;

  pic_cmd_decode #(.DATA_W(DATA_W), .LINE_W(LINE_W)) u_dec (
    .wr(wr), .addr(addr), .wdata(wdata),
    .icw1(icw1), .ocw(ocw), .data1(data1),
    .sel_req(sel_req), .sel_svc(sel_svc),
    .nseoi(nseoi), .seoi(seoi), .seoi_line(seoi_line)
  );

  pic_init_seq #(.VB_W(VB_W)) u_init (
    .clk(clk), .rst_n(rst_n),
    .icw1(icw1), .ocw(ocw), .data1(data1),
    .vb_din(wdata[DATA_W-1:3]),
    .mask_we(mask_we), .vec_base(vec_base)
  );

  pic_prio_core #(.N_IRQ(N_IRQ), .LINE_W(LINE_W)) u_core (
    .clk(clk), .rst_n(rst_n),
    .irq_in(irq_in), .ack(ack),
    .nseoi(nseoi), .seoi(seoi), .seoi_line(seoi_line),
    .mask_we(mask_we), .mask_din(wdata[N_IRQ-1:0]),
    .irr(irr), .isr(isr), .imr(imr), .int_out(int_out)
  );

  always_comb begin
    if (addr)                rd_mux = DATA_W'(imr);
    else if (rsel == SEL_SVC) rd_mux = DATA_W'(isr);
    else                      rd_mux = DATA_W'(irr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsel  <= SEL_REQ;
      rdata <= '0;
    end else begin
      if (sel_req)      rsel <= SEL_REQ;
      else if (sel_svc) rsel <= SEL_SVC;
      if (rd) rdata <= rd_mux;
    end
  end

  p_mask_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (imr == $past(wdata[N_IRQ-1:0])));

  p_svc_select_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !addr && (rsel == SEL_SVC)) |=> (rdata == DATA_W'($past(isr))));
endmodule

// File: tb/pic_regif_bench.sv
`timescale 1ns/1ps
module pic_regif_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr = 1'b0, wr = 1'b0, rd = 1'b0, ack = 1'b0;
  logic [7:0] wdata = '0, irq_in = '0, rdata;
  logic int_out;
  logic [4:0] vec_base;

  int checks = 0, misses = 0;

  // bench model state
  logic [7:0] m_irr = '0, m_isr = '0, m_imr = '0, m_prev = '0;
  logic       m_sel = 1'b0;
  int         m_st = 0;
  logic [4:0] m_vb = '0;

  always #4 clk = ~clk;

  pic_regif u_pic_regif (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
    .rdata(rdata), .irq_in(irq_in), .ack(ack), .int_out(int_out), .vec_base(vec_base)
  );

  function automatic logic [7:0] f_cand(logic [7:0] q, logic [7:0] s, logic [7:0] k);
    logic [7:0] c = '0;
    for (int i = 0; i < 8; i++) begin
      logic blocked = 1'b0;
      for (int j = 0; j <= i; j++) if (s[j]) blocked = 1'b1;
      if (q[i] && !k[i] && !blocked) c[i] = 1'b1;
    end
    return c;
  endfunction

  function automatic logic [7:0] f_win(logic [7:0] c);
    for (int i = 0; i < 8; i++) if (c[i]) return 8'(1) << i;
    return '0;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic s_wr, logic s_addr, logic [7:0] s_d,
                      logic s_rd, logic s_ack, logic [7:0] s_irq);
    logic [7:0] rise, grant, clr_q, clr_s, exp_rd, oh;
    logic is0, icw1, ocw, d1, nse, se;
    @(negedge clk);
    wr = s_wr; addr = s_addr; wdata = s_d; rd = s_rd; ack = s_ack; irq_in = s_irq;
    rise   = s_irq & ~m_prev;
    grant  = s_ack ? f_win(f_cand(m_irr, m_isr, m_imr)) : '0;
    exp_rd = s_addr ? m_imr : (m_sel ? m_isr : m_irr);
    is0  = s_wr && !s_addr;
    icw1 = is0 && s_d[4];
    ocw  = is0 && !s_d[4];
    d1   = s_wr && s_addr;
    nse  = ocw && (s_d == 8'h20);
    se   = ocw && (s_d[7:3] == 5'b01100);
    oh   = 8'(1) << s_d[2:0];
    clr_q = grant; clr_s = '0;
    if (nse) begin clr_q |= m_isr; clr_s = '1; end
    if (se)  begin clr_q |= oh;    clr_s |= oh; end
    @(posedge clk);
    #1;
    m_prev = s_irq;
    if (icw1) m_st = 1;
    else if (ocw) m_st = 0;
    else if (d1) begin
      case (m_st)
        0: m_imr = s_d;
        1: begin m_vb = s_d[7:3]; m_st = 2; end
        2: m_st = 3;
        default: m_st = 0;
      endcase
    end
    if (ocw && s_d == 8'h0A) m_sel = 1'b0;
    if (ocw && s_d == 8'h0B) m_sel = 1'b1;
    m_irr = (m_irr & ~clr_q) | rise;
    m_isr = (m_isr & ~clr_s) | grant;
    check({tag, "/R11 int_out"}, {7'd0, int_out}, {7'd0, |f_cand(m_irr, m_isr, m_imr)});
    check({tag, "/R3 vec_base"}, {3'd0, vec_base}, {3'd0, m_vb});
    if (s_rd) check({tag, s_addr ? "/R8 read" : "/R5 read"}, rdata, exp_rd);
  endtask

  task automatic wr_(string tag, logic a, logic [7:0] d);
    step(tag, 1'b1, a, d, 1'b0, 1'b0, irq_in);
  endtask

  task automatic rd_(string tag, logic a);
    step(tag, 1'b0, a, 8'h00, 1'b1, 1'b0, irq_in);
  endtask

  initial begin
    #(200000 * 8);
    misses++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, misses);
    $finish;
  end

  initial begin
    logic [7:0] q;
    void'($urandom(32'h5EED_0259));
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    check("R1 int_out", {7'd0, int_out}, 8'h00);
    check("R1 vec_base", {3'd0, vec_base}, 8'h00);
    rd_("R1", 1'b0); check("R1 irr read", rdata, 8'h00);
    rd_("R1", 1'b1); check("R1 mask read", rdata, 8'h00);

    // R2/R3 full init sequence
    wr_("R2", 1'b0, 8'h1B);
    wr_("R3", 1'b1, 8'h47);
    check("R3 vec_base", {3'd0, vec_base}, 8'h08);
    wr_("R3", 1'b1, 8'hFF);
    rd_("R3", 1'b1); check("R3 word3 ignored mask", rdata, 8'h00);
    check("R3 word3 vb kept", {3'd0, vec_base}, 8'h08);
    wr_("R3", 1'b1, 8'h01);
    wr_("R8", 1'b1, 8'hF0);
    rd_("R8", 1'b1); check("R8 mask", rdata, 8'hF0);

    // R4 abort
    wr_("R4", 1'b0, 8'h10);
    wr_("R4", 1'b1, 8'h28);
    wr_("R4", 1'b0, 8'h0B);
    wr_("R4", 1'b1, 8'h3C);
    rd_("R4", 1'b1); check("R4 mask after abort", rdata, 8'h3C);
    check("R4 vb", {3'd0, vec_base}, 8'h05);
    wr_("R8", 1'b1, 8'h00);

    // R10/R12 edge then ack
    step("R10", 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h04);
    check("R10 int", {7'd0, int_out}, 8'h01);
    step("R12", 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h04);
    rd_("R12", 1'b0); check("R12 isr", rdata, 8'h04);
    wr_("R5", 1'b0, 8'h0A);
    repeat (3) rd_("R10", 1'b0);
    check("R10 held no relatch", rdata, 8'h00);

    // R11 lower line outranks service
    step("R11", 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h06);
    check("R11 line1 over svc2", {7'd0, int_out}, 8'h01);
    step("R11", 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h26);
    // R12 ack together with non-specific EOI
    step("R12", 1'b1, 1'b0, 8'h20, 1'b0, 1'b1, 8'h26);
    wr_("R5", 1'b0, 8'h0B);
    rd_("R12", 1'b0); check("R12 ack+nseoi isr", rdata, 8'h02);
    wr_("R5", 1'b0, 8'h0A);
    rd_("R6", 1'b0); check("R6 irr", rdata, 8'h20);

    // R9 no-effect commands
    wr_("R9", 1'b0, 8'h68);
    wr_("R9", 1'b0, 8'hC3);
    wr_("R9", 1'b0, 8'h47);
    rd_("R9", 1'b0); check("R9 irr kept", rdata, 8'h20);
    rd_("R9", 1'b1); check("R9 mask kept", rdata, 8'h00);

    // R7 specific EOI, with rise on same line (R10 set wins)
    wr_("R7", 1'b0, 8'h61);
    wr_("R5", 1'b0, 8'h0B);
    rd_("R7", 1'b0); check("R7 isr", rdata, 8'h00);
    step("R10", 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00);
    step("R10", 1'b1, 1'b0, 8'h65, 1'b0, 1'b0, 8'h20);
    wr_("R5", 1'b0, 8'h0A);
    rd_("R10", 1'b0); check("R10 rise beats clear", rdata, 8'h20);

    // random phase
    q = irq_in;
    for (int n = 0; n < 4000; n++) begin
      int op = $urandom_range(0, 9);
      logic [7:0] d;
      logic a_ack = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 2) == 0) q = q ^ 8'($urandom_range(0, 255));
      case ($urandom_range(0, 7))
        0: d = 8'h0A;
        1: d = 8'h0B;
        2: d = 8'h20;
        3: d = 8'h60 | 8'($urandom_range(0, 7));
        4: d = 8'h68;
        5: d = 8'hC0 | 8'($urandom_range(0, 7));
        6: d = ($urandom_range(0, 5) == 0) ? 8'h11 : 8'h20;
        default: d = 8'($urandom_range(0, 255)) & 8'hEF;
      endcase
      case (op)
        0, 1: step("R6", 1'b1, 1'b0, d, 1'b0, a_ack, q);
        2:    step("R8", 1'b1, 1'b1, 8'($urandom_range(0, 255)), 1'b0, a_ack, q);
        3, 4: step("R5", 1'b0, 1'b0, 8'h00, 1'b1, a_ack, q);
        5:    step("R8", 1'b0, 1'b1, 8'h00, 1'b1, a_ack, q);
        default: step("R12", 1'b0, 1'b0, 8'h00, 1'b0, a_ack, q);
      endcase
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, misses);
    $finish;
  end
endmodule